// File: doc/BRIEF.md
# Flash Status Polling Read Responder

This block sits on the read path of a NOR-style flash device model. While an internal program, erase or blank-check algorithm runs, it replaces array data with a status word. Bit 7 of that word is the polled completion bit: the inverted programmed value during a program, 0 during an erase or blank check, and 1 for an erase that has been suspended. When the algorithm ends, reads return array data again. The array then holds the true programmed value, or all ones after an erase.

The block is started by a one-cycle command-accepted strobe, which stands in for the rising edge of the last write-enable pulse. The strobe arrives with the operation kind, the bit-7 value being programmed, the target address and a protection flag for the target sector. The command decoder and the algorithm timing stay outside the block: the end of an operation arrives as a one-cycle done strobe. For a protected target the block runs its own false-busy window, about 20 µs for a program and about 100 µs for an erase or blank check. It counts this window in clock cycles derived from the clock frequency parameter, then falls back to array data without any done strobe.

Top module: `flash_poll_responder`

## Requirements
- R1: While an operation is active and not program-suspended, `sel_status` is 1 and every read address returns the status word in place of `array_data`. Every bit of the word except bit 7 is the same at every address.
- R2: Every bit of the status word other than bit 7 reads 0. This includes the reserved bits 15..8, 4 and 0.
- R3: Operation kind encoding on `op_kind`: 0 none, 1 program, 2 erase, 3 blank check. During a program, bit 7 at the target address is the inverse of `tgt_dbit`.
- R4: During an erase or blank check, bit 7 is 0 at any address whose top `SECT_W` bits equal those of the target address.
- R5: During an erase, `erase_susp` = 1 makes bit 7 read 1 at the valid addresses. During a blank check, `erase_susp` has no effect.
- R6: At any address outside the valid region, bit 7 is the complement of the valid-address value. For a program the valid region is the exact target address; for an erase or blank check it is the target sector.
- R7: A program with `tgt_prot` = 1 shows the program status for exactly `PROG_US*CLK_HZ/1e6` cycles and then returns array data. `op_done`, `prog_susp` and `erase_susp` are ignored during this window.
- R8: An erase or blank check with `tgt_prot` = 1 shows status with bit 7 = 0 for exactly `ERASE_US*CLK_HZ/1e6` cycles and then returns array data.
- R9: Status output starts in the cycle after the clock edge that samples `op_start`. In the strobe's own cycle, reads still return array data.
- R10: During a program, `prog_susp` = 1 makes reads return `array_data` in the same cycle. Status reappears once `prog_susp` drops.
- R11: `op_start` is ignored while an operation is active, and it is ignored when `op_kind` is 0.
- R12: After reset the block is idle: `sel_status` is 0 and `rd_data` equals `array_data`.
- R13: `op_done` ends an unprotected operation, and array data is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Command accepted strobe (final write-enable rising edge) |
| op_kind | input | 2 | Operation kind: 0 none, 1 program, 2 erase, 3 blank check |
| op_done | input | 1 | Algorithm finished strobe from the timing stub |
| prog_susp | input | 1 | Program suspend active |
| erase_susp | input | 1 | Erase suspend active |
| tgt_dbit | input | 1 | Value of data bit 7 being programmed |
| tgt_addr | input | ADDR_W | Program word address, or any address in the erase sector |
| tgt_prot | input | 1 | Target sector is protected |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | DATA_W | Array word at `rd_addr` |
| rd_data | output | DATA_W | Word returned on the data bus |
| sel_status | output | 1 | 1 when `rd_data` carries the status word |

## Verification
The hardest situation to reach is the protected-target window: `op_done` and both suspend flags must be shown to have no effect, and the end must land on an exact cycle count. The bench uses a 1 MHz clock-frequency parameter, which shrinks the windows to 20 and 100 cycles. It samples `sel_status` in every cycle of each window, pulses `op_done` and the suspend flags partway through, and checks the first cycle after the window ends. Address-dependent bit 7 is covered by sweeping all 64 read addresses of the small configuration inside one clock phase, in every operation and suspend state.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_BLANK = 2'd3
   } op_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_ABORT = 2'd2
   } poll_st_e;

   localparam int unsigned POLL_BIT = 7;
endpackage

// File: rtl/fpr_abort_timer.sv
`timescale 1ns/1ps
module fpr_abort_timer #(
   parameter int unsigned PROG_WIN  = 20,
   parameter int unsigned ERASE_WIN = 100,
   localparam int unsigned MAX_WIN  = (PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN,
   localparam int unsigned CNT_W    = $clog2(MAX_WIN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic is_prog,
   output logic last
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= is_prog ? CNT_W'(PROG_WIN) : CNT_W'(ERASE_WIN);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/fpr_addr_match.sv
`timescale 1ns/1ps
module fpr_addr_match #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned SECT_W = 3
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              is_prog,
   output logic              hit
);
   logic sect_hit;

   generate
      if (SECT_W == 0) begin : g_one_sector
         assign sect_hit = 1'b1;
      end else begin : g_sectors
         assign sect_hit = (rd_addr[ADDR_W-1 -: SECT_W] == tgt_addr[ADDR_W-1 -: SECT_W]);
      end
   endgenerate

   assign hit = is_prog ? (rd_addr == tgt_addr) : sect_hit;
endmodule

// File: rtl/fpr_status_word.sv
`timescale 1ns/1ps
module fpr_status_word #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned BIT_POS = 7
) (
   input  logic              valid_bit,
   input  logic              addr_hit,
   output logic [DATA_W-1:0] word
);
   always_comb begin
      word          = '0;
      word[BIT_POS] = addr_hit ? valid_bit : ~valid_bit;
   end
endmodule

// File: rtl/flash_poll_responder.sv
`timescale 1ns/1ps
module flash_poll_responder #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned SECT_W   = 3,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned CLK_HZ   = 100_000_000,
   parameter int unsigned PROG_US  = 20,
   parameter int unsigned ERASE_US = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic              op_done,
   input  logic              prog_susp,
   input  logic              erase_susp,
   input  logic              tgt_dbit,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic              tgt_prot,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              sel_status
);
   import fpr_pkg::*;

   localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int unsigned PROG_WIN   = CYC_PER_US * PROG_US;
   localparam int unsigned ERASE_WIN  = CYC_PER_US * ERASE_US;

   generate
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("CLK_HZ must be at least 1 MHz");
      end
      if (DATA_W <= POLL_BIT) begin : g_bad_width
         $error("DATA_W must hold the polled bit");
      end
      if (SECT_W > ADDR_W) begin : g_bad_sect
         $error("SECT_W must not exceed ADDR_W");
      end
      if (PROG_US == 0 || ERASE_US == 0) begin : g_bad_win
         $error("abort windows must be non-zero");
      end
   endgenerate

   poll_st_e          st;
   op_kind_e          kind_q;
   logic              dbit_q;
   logic [ADDR_W-1:0] tgt_q;
   logic              start_ok;
   logic              timer_last;
   logic              is_prog;
   logic              addr_hit;
   logic              valid_bit;
   logic [DATA_W-1:0] status_word;

   assign start_ok = op_start && (op_kind != OP_NONE) && (st == ST_IDLE);
   assign is_prog  = (kind_q == OP_PROG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         kind_q <= OP_NONE;
         dbit_q <= 1'b0;
         tgt_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start_ok) begin
               st     <= tgt_prot ? ST_ABORT : ST_RUN;
               kind_q <= op_kind_e'(op_kind);
               dbit_q <= tgt_dbit;
               tgt_q  <= tgt_addr;
            end
            ST_RUN:   if (op_done)    st <= ST_IDLE;
            ST_ABORT: if (timer_last) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   fpr_abort_timer #(
      .PROG_WIN (PROG_WIN),
      .ERASE_WIN(ERASE_WIN)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start_ok && tgt_prot),
      .is_prog(op_kind == OP_PROG),
      .last   (timer_last)
   );

   fpr_addr_match #(
      .ADDR_W(ADDR_W),
      .SECT_W(SECT_W)
   ) u_match (
      .rd_addr (rd_addr),
      .tgt_addr(tgt_q),
      .is_prog (is_prog),
      .hit     (addr_hit)
   );

   always_comb begin
      if (is_prog)
         valid_bit = ~dbit_q;
      else
         valid_bit = (st == ST_RUN) && (kind_q == OP_ERASE) && erase_susp;
   end

   fpr_status_word #(
      .DATA_W (DATA_W),
      .BIT_POS(POLL_BIT)
   ) u_word (
      .valid_bit(valid_bit),
      .addr_hit (addr_hit),
      .word     (status_word)
   );

   always_comb begin
      unique case (st)
         ST_RUN:   sel_status = !(is_prog && prog_susp);
         ST_ABORT: sel_status = 1'b1;
         default:  sel_status = 1'b0;
      endcase
   end

   assign rd_data = sel_status ? status_word : array_data;
endmodule

// File: rtl/fpr_checker.sv
`timescale 1ns/1ps
module fpr_checker #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ERASE_WIN = 100
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_start,
   input logic [1:0]        op_kind,
   input logic              op_done,
   input logic              prog_susp,
   input logic [1:0]        st,
   input logic [1:0]        kind_q,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] array_data,
   input logic              sel_status
);
   localparam logic [1:0] S_IDLE  = 2'd0;
   localparam logic [1:0] S_RUN   = 2'd1;
   localparam logic [1:0] S_ABORT = 2'd2;

   logic [31:0] abort_run;
   always_ff @(posedge clk) begin
      if (!rst_n)              abort_run <= '0;
      else if (st == S_ABORT)  abort_run <= abort_run + 1;
      else                     abort_run <= '0;
   end

   p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_status |-> (rd_data[DATA_W-1:8] == '0 && rd_data[6:0] == '0));

   p_idle_array_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_status |-> (rd_data == array_data));

   p_no_status_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !sel_status);

   p_start_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && op_start && op_kind != 2'd0) |=> (sel_status || prog_susp));

   p_done_ends_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN && op_done) |=> !sel_status);

   p_abort_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ABORT) |-> sel_status);

   p_prog_susp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RUN && kind_q == 2'd1 && prog_susp) |-> !sel_status);

   p_kind_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE) |=> (st == S_IDLE || $stable(kind_q)));

   p_window_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_run <= ERASE_WIN);
endmodule

bind flash_poll_responder fpr_checker #(
   .DATA_W   (DATA_W),
   .ERASE_WIN(ERASE_WIN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_start  (op_start),
   .op_kind   (op_kind),
   .op_done   (op_done),
   .prog_susp (prog_susp),
   .st        (st),
   .kind_q    (kind_q),
   .rd_data   (rd_data),
   .array_data(array_data),
   .sel_status(sel_status)
);

// File: tb/flash_poll_responder_test.sv
`timescale 1ns/1ps
module flash_poll_responder_test;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam logic [15:0] MASK = 16'h00EE;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 1'b0;
   logic [1:0]    op_kind = 2'd0;
   logic          op_done = 1'b0;
   logic          prog_susp = 1'b0;
   logic          erase_susp = 1'b0;
   logic          tgt_dbit = 1'b0;
   logic [AW-1:0] tgt_addr = '0;
   logic          tgt_prot = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] array_data;
   logic [DW-1:0] rd_data;
   logic          sel_status;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   function automatic logic [15:0] arr(input logic [5:0] a);
      return {a, 2'b01, ~a, 2'b10};
   endfunction

   assign array_data = arr(rd_addr);

   flash_poll_responder #(
      .ADDR_W(AW), .SECT_W(2), .DATA_W(DW),
      .CLK_HZ(1_000_000), .PROG_US(20), .ERASE_US(100)
   ) uut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
      .op_done(op_done), .prog_susp(prog_susp), .erase_susp(erase_susp),
      .tgt_dbit(tgt_dbit), .tgt_addr(tgt_addr), .tgt_prot(tgt_prot),
      .rd_addr(rd_addr), .array_data(array_data), .rd_data(rd_data),
      .sel_status(sel_status)
   );

   task automatic check(input logic ok, input string rq,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // Sweeps every read address inside one low clock phase.
   task automatic sweep(input logic es, input logic vb, input logic is_prog,
                        input logic [5:0] tgt, input string rq);
      for (int a = 0; a < 64; a++) begin
         logic [5:0]  ad;
         logic        hit;
         logic        b;
         logic [15:0] exp;
         ad = 6'(a);
         rd_addr = ad;
         #0.04;
         hit = is_prog ? (ad == tgt) : (ad[5:4] == tgt[5:4]);
         b   = hit ? vb : !vb;
         exp = es ? {8'h00, b, 7'h00} : arr(ad);
         if (es)
            check(sel_status && (((rd_data ^ exp) & MASK) == 16'h0), rq,
                  rd_data, exp);
         else
            check(!sel_status && (rd_data == exp), rq, rd_data, exp);
      end
   endtask

   task automatic start_op(input int k, input logic d, input logic [5:0] t,
                           input logic p, input logic chk_pre);
      @(negedge clk);
      op_kind  = 2'(k);
      tgt_dbit = d;
      tgt_addr = t;
      tgt_prot = p;
      op_start = 1'b1;
      #1;
      if (chk_pre)
         check(!sel_status && rd_data == array_data, "R9 pre-start",
               {15'h0, sel_status}, 16'h0);
      @(negedge clk);
      op_start = 1'b0;
      op_kind  = 2'd0;
      #0.5;
   endtask

   initial begin
      #3_000_000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #0.5;
      sweep(1'b0, 1'b0, 1'b0, 6'd0, "R12 reset");
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      sweep(1'b0, 1'b0, 1'b0, 6'd0, "R12 idle");

      // R11: op_start with kind 0 is ignored
      start_op(0, 1'b0, 6'd5, 1'b0, 1'b0);
      sweep(1'b0, 1'b0, 1'b0, 6'd0, "R11 kind none");

      for (int k = 1; k <= 3; k++) begin
         for (int d = 0; d < 2; d++) begin
            logic [5:0] t;
            logic       vb;
            logic       pg;
            t  = 6'((k * 13 + d * 7) % 64);
            pg = (k == 1);
            vb = pg ? (d == 0) : 1'b0;
            start_op(k, 1'(d), t, 1'b0, 1'b1);
            sweep(1'b1, vb, pg, t, "R1 R3 R4 R6 active");
            if (pg) begin
               @(negedge clk); prog_susp = 1'b1; #0.5;
               sweep(1'b0, 1'b0, 1'b0, t, "R10 program suspend");
               @(negedge clk); prog_susp = 1'b0; #0.5;
               sweep(1'b1, vb, pg, t, "R10 resume");
            end else begin
               @(negedge clk); erase_susp = 1'b1; #0.5;
               sweep(1'b1, (k == 2), pg, t, "R5 erase suspend");
               @(negedge clk); erase_susp = 1'b0; #0.5;
               sweep(1'b1, 1'b0, pg, t, "R5 released");
            end
            // R11: a second command while active is ignored
            start_op(1, !1'(d), t ^ 6'h3F, 1'b1, 1'b0);
            sweep(1'b1, vb, pg, t, "R11 restart ignored");
            @(negedge clk); op_done = 1'b1;
            @(negedge clk); op_done = 1'b0; #0.5;
            sweep(1'b0, 1'b0, 1'b0, t, "R13 done");
         end
      end

      // R7 / R8: protected targets
      for (int k = 1; k <= 3; k++) begin
         int         win;
         logic [5:0] t;
         logic       vb;
         t   = 6'(k * 11);
         win = (k == 1) ? 20 : 100;
         vb  = (k == 1) ? 1'b0 : 1'b0;
         start_op(k, (k == 1), t, 1'b1, 1'b1);
         sweep(1'b1, vb, (k == 1), t, (k == 1) ? "R7 window" : "R8 window");
         for (int c = 1; c <= win; c++) begin
            rd_addr = t;
            #0.2;
            check(sel_status && rd_data[7] == vb,
                  (k == 1) ? "R7 busy cycle" : "R8 busy cycle",
                  rd_data, {8'h00, vb, 7'h00});
            @(negedge clk);
            op_done    = (c == 3);
            prog_susp  = (c == 4);
            erase_susp = (c == 4);
            #0.5;
         end
         op_done = 1'b0; prog_susp = 1'b0; erase_susp = 1'b0;
         rd_addr = t;
         #0.2;
         check(!sel_status && rd_data == arr(t),
               (k == 1) ? "R7 window end" : "R8 window end",
               rd_data, arr(t));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule